// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external 8K x 8 asynchronous static RAM. The host issues one read or write at a time through a ready/valid request port. The block turns each request into strobe sequences that respect the RAM's access, pulse, setup, cycle and bus-float times. Each of these times is a parameter in nanoseconds and is rounded up to whole clock cycles when the block is elaborated.

The RAM is enabled only while its active-low select is low and its active-high select is high. Between operations the sequencer parks the RAM in standby. By default it does this by also pulling the active-high select low, which is the low-power case. A write is committed at the end of the overlap of select and write strobe, so the block drives the data bus before the strobe falls and holds it after the strobe rises. The data bus is split into an output, an output-enable and an input, and a pad tri-state combines them. Before a write that follows a read, the block waits long enough for the RAM's output drivers to float.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever no operation is in progress, req_ready is 1 and the RAM is in standby: mem_cs1_n=1, mem_cs2=0 (with the default low-power parking), mem_oe_n=1, mem_we_n=1, mem_dq_oe=0, rsp_valid=0.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready goes to 0 in the cycle after acceptance and stays 0 until the operation's last cycle has passed.
- R3: A read holds mem_cs1_n=0, mem_cs2=1, mem_oe_n=0, mem_we_n=1 and a steady mem_addr for ACC cycles. ACC is the largest of address access, output-enable access and read cycle time, each rounded up to clocks (10 at defaults). mem_dq_in is then sampled on the edge that ends that window.
- R4: rsp_valid is 1 for exactly the one cycle after the read window. rsp_rdata shows the sampled byte then and keeps it until the next read completes.
- R5: A write begins with one cycle that is selected, with mem_we_n=1, mem_oe_n=1 and data driven. Then mem_we_n stays 0 for PULSE cycles, the larger of write pulse width and data setup rounded up (6 at defaults), with data and address unchanged.
- R6: When mem_we_n rises, the RAM is deselected in the same edge, but mem_dq_oe, data and address stay for a recovery period. The recovery period makes the write total at least the write cycle time (10 cycles at defaults, recovery 3).
- R7: mem_dq_oe is never 1 while the RAM could drive the bus (selected with mem_oe_n=0), and mem_oe_n stays 1 for the whole write.
- R8: A write accepted after a read is preceded by TA deselected, undriven cycles, the bus float time rounded up (4 at defaults). A write after a write, or a first write, starts with its setup cycle at once.
- R9: Address and write data are captured at acceptance. Later changes on req_addr, req_wdata and req_write do not alter mem_addr or mem_dq_out during the operation.
- R10: A read returns the byte most recently written to that address, as latched by the RAM at the end of the write overlap. An address that was never written returns the RAM's initial content, which the bench model sets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Last read data |
| mem_addr | output | 13 | RAM address bus |
| mem_cs1_n | output | 1 | RAM select, active low |
| mem_cs2 | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_in | input | 8 | Data from the RAM |

## Verification
Every output is registered, so the strobes change in the cycle after the edge that accepts a request. From that cycle onward, a read shows 10 access cycles and then one response cycle, and a write shows 1 setup cycle, 6 strobe cycles and 3 recovery cycles, with 4 float cycles placed first when a read came just before. The bench's reference model turns each accepted request into one expected entry per cycle from that next cycle on, and compares the strobes, the address, the data and the response at every falling edge. The bench's RAM model presents valid data only after the access window has been held for the full count, so sampling one edge early returns corrupted data. It also counts how long write data stayed stable and how many clocks passed since the RAM last drove the bus.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACCESS,
      ST_RD_DONE,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RECOVER,
      ST_TURNAROUND
   } ctl_state_e;

   typedef struct packed {
      logic sel;
      logic oe_n;
      logic we_n;
      logic drive;
   } strobe_t;

   function automatic int unsigned ns_to_clk(int unsigned ns, int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned umax(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic strobe_t strobe_for(ctl_state_e s);
      strobe_t r;
      r = '{sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
      case (s)
         ST_RD_ACCESS:  r = '{sel: 1'b1, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
         ST_WR_SETUP:   r = '{sel: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
         ST_WR_PULSE:   r = '{sel: 1'b1, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
         ST_WR_RECOVER: r = '{sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
         default:       r = '{sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   a_r3_timer_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && ($past(cnt_q) != '0)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (capture)
         rdata_q <= mem_dq_in;
   end

   a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(accept) |-> $stable(addr_q));

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ACC_CYC   = 10,
   parameter int unsigned PULSE_CYC = 6,
   parameter int unsigned REC_CYC   = 3,
   parameter int unsigned TA_CYC    = 4,
   parameter int unsigned CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_expired,
   output logic             req_ready,
   output logic             accept,
   output logic             capture,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output strobe_t          strobe,
   output logic             rsp_valid
);

   ctl_state_e state_q, state_d;
   logic       last_rd_q;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (!req_write) begin
                  state_d = ST_RD_ACCESS;
                  tmr_val = CNT_W'(ACC_CYC - 1);
               end else if (last_rd_q) begin
                  state_d = ST_TURNAROUND;
                  tmr_val = CNT_W'(TA_CYC - 1);
               end else begin
                  state_d = ST_WR_SETUP;
               end
            end
         end
         ST_RD_ACCESS: begin
            if (tmr_expired) begin
               state_d = ST_RD_DONE;
               capture = 1'b1;
            end
         end
         ST_RD_DONE: state_d = ST_IDLE;
         ST_TURNAROUND: begin
            if (tmr_expired)
               state_d = ST_WR_SETUP;
         end
         ST_WR_SETUP: begin
            state_d  = ST_WR_PULSE;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(PULSE_CYC - 1);
         end
         ST_WR_PULSE: begin
            if (tmr_expired) begin
               state_d  = ST_WR_RECOVER;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(REC_CYC - 1);
            end
         end
         ST_WR_RECOVER: begin
            if (tmr_expired)
               state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         strobe    <= strobe_for(ST_IDLE);
         rsp_valid <= 1'b0;
         last_rd_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         strobe    <= strobe_for(state_d);
         rsp_valid <= (state_d == ST_RD_DONE);
         if (accept)
            last_rd_q <= !req_write;
      end
   end

   a_r3_read_keeps_we_high: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe.oe_n |-> (strobe.we_n && strobe.sel));

   a_r8_setup_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_RD_DONE) |-> !strobe.drive);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W         = 13,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned CLK_NS         = 10,
   parameter int unsigned T_ACC_NS       = 100,
   parameter int unsigned T_OE_NS        = 50,
   parameter int unsigned T_RC_NS        = 100,
   parameter int unsigned T_WP_NS        = 60,
   parameter int unsigned T_DW_NS        = 50,
   parameter int unsigned T_WC_NS        = 100,
   parameter int unsigned T_FLOAT_NS     = 35,
   parameter bit          PARK_LOW_POWER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned ACC_CYC   = umax(1, umax(ns_to_clk(T_ACC_NS, CLK_NS),
                                        umax(ns_to_clk(T_OE_NS, CLK_NS), ns_to_clk(T_RC_NS, CLK_NS))));
   localparam int unsigned PULSE_CYC = umax(1, umax(ns_to_clk(T_WP_NS, CLK_NS), ns_to_clk(T_DW_NS, CLK_NS)));
   localparam int unsigned WC_CYC    = ns_to_clk(T_WC_NS, CLK_NS);
   localparam int unsigned REC_CYC   = (WC_CYC > PULSE_CYC + 2) ? (WC_CYC - PULSE_CYC - 1) : 1;
   localparam int unsigned TA_CYC    = umax(1, ns_to_clk(T_FLOAT_NS, CLK_NS));
   localparam int unsigned MAX_CYC   = umax(umax(ACC_CYC, PULSE_CYC), umax(REC_CYC, TA_CYC));
   localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

   initial begin
      assert (CLK_NS > 0) else $error("sram_ctl: CLK_NS must be nonzero");
      assert (ADDR_W > 0 && DATA_W > 0) else $error("sram_ctl: bus widths must be nonzero");
   end

   logic             accept, capture, tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val;
   strobe_t          strobe;

   sram_ctl_fsm #(
      .ACC_CYC(ACC_CYC), .PULSE_CYC(PULSE_CYC), .REC_CYC(REC_CYC),
      .TA_CYC(TA_CYC), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .tmr_expired(tmr_expired), .req_ready(req_ready), .accept(accept),
      .capture(capture), .tmr_load(tmr_load), .tmr_val(tmr_val),
      .strobe(strobe), .rsp_valid(rsp_valid)
   );

   sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .expired(tmr_expired)
   );

   sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
      .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
      .addr_q(mem_addr), .wdata_q(mem_dq_out), .rdata_q(rsp_rdata)
   );

   assign mem_cs1_n = ~strobe.sel;
   assign mem_oe_n  = strobe.oe_n;
   assign mem_we_n  = strobe.we_n;
   assign mem_dq_oe = strobe.drive;

   generate
      if (PARK_LOW_POWER) begin : g_park_low
         assign mem_cs2 = strobe.sel;
      end else begin : g_park_cs1
         assign mem_cs2 = 1'b1;
      end
   endgenerate

   a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   a_r5_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_dq_oe && mem_oe_n));

   a_r6_data_held_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

   a_r4_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r1_ready_parked: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs1_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   a_r9_addr_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

   localparam int ACC   = 10;
   localparam int PULSE = 6;
   localparam int REC   = 3;
   localparam int TA    = 4;
   localparam int DW    = 5;

   // {ready, cs1_n, cs2, oe_n, we_n, dq_oe, rsp_valid}
   localparam logic [6:0] V_IDLE  = 7'b1101100;
   localparam logic [6:0] V_RDACC = 7'b0010100;
   localparam logic [6:0] V_RDEND = 7'b0101101;
   localparam logic [6:0] V_GAP   = 7'b0101100;
   localparam logic [6:0] V_SETUP = 7'b0011110;
   localparam logic [6:0] V_PULSE = 7'b0011010;
   localparam logic [6:0] V_REC   = 7'b0101110;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [12:0] req_addr  = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [12:0] mem_addr;
   logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = '0;

   sram_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   typedef struct {
      logic [6:0]  v;
      string       tag;
      bit          ca;
      logic [12:0] a;
      bit          cw;
      logic [7:0]  w;
      bit          cr;
      logic [7:0]  r;
      string       rtag;
   } exp_t;

   exp_t       q[$];
   logic [7:0] ram [int];
   logic [7:0] ref_mem [int];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   bit         last_rd = 1'b0;
   bit         have_rd = 1'b0;
   logic [7:0] last_rdata = '0;

   int          held = 0;
   bit          prev_rd = 1'b0;
   logic [12:0] rd_addr = '0;
   int          since = 1000;
   bit          ov_prev = 1'b0;
   int          ov_cnt = 0;
   logic [7:0]  ov_d = '0;
   logic [12:0] ov_a = '0;

   exp_t        cur;
   logic [6:0]  act;
   bit          rd_now, ov_now;

   function automatic logic [7:0] ram_get(int a);
      return ram.exists(a) ? ram[a] : 8'h00;
   endfunction

   function automatic logic [7:0] ref_get(int a);
      return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
   endfunction

   function automatic exp_t mk(logic [6:0] v, string tag);
      exp_t e;
      e.v = v; e.tag = tag; e.ca = 1'b0; e.a = '0; e.cw = 1'b0; e.w = '0;
      e.cr = 1'b0; e.r = '0; e.rtag = "R4";
      return e;
   endfunction

   task automatic chk(bit ok, string tag, string what, int act_v, int exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act_v, exp_v, $time);
      end
   endtask

   task automatic push_op(bit w, logic [12:0] a, logic [7:0] d);
      exp_t e;
      int first;
      first = q.size();
      if (w) begin
         if (last_rd)
            repeat (TA) q.push_back(mk(V_GAP, "R8"));
         e = mk(V_SETUP, "R5"); e.ca = 1'b1; e.a = a; e.cw = 1'b1; e.w = d;
         q.push_back(e);
         e.v = V_PULSE;
         repeat (PULSE) q.push_back(e);
         e.v = V_REC; e.tag = "R6";
         repeat (REC) q.push_back(e);
         ref_mem[int'(a)] = d;
         last_rd = 1'b0;
      end else begin
         e = mk(V_RDACC, "R3"); e.ca = 1'b1; e.a = a;
         repeat (ACC) q.push_back(e);
         e = mk(V_RDEND, "R4"); e.cr = 1'b1; e.r = ref_get(int'(a)); e.rtag = "R10";
         q.push_back(e);
         have_rd = 1'b1;
         last_rdata = e.r;
         last_rd = 1'b1;
      end
      q[first].tag = "R2";
   endtask

   // reference model and RAM model, evaluated mid-cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (q.size() > 0) begin
            cur = q.pop_front();
         end else begin
            cur = mk(V_IDLE, "R1");
            if (have_rd) begin cur.cr = 1'b1; cur.r = last_rdata; end
         end
         act = {req_ready, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid};
         chk(act === cur.v, cur.tag, "strobes", int'(act), int'(cur.v));
         if (cur.ca) chk(mem_addr === cur.a, "R9", "mem_addr", int'(mem_addr), int'(cur.a));
         if (cur.cw) chk(mem_dq_out === cur.w, "R9", "mem_dq_out", int'(mem_dq_out), int'(cur.w));
         if (cur.cr) chk(rsp_rdata === cur.r, cur.rtag, "rsp_rdata", int'(rsp_rdata), int'(cur.r));

         rd_now = !mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n;
         if (rd_now && prev_rd && mem_addr == rd_addr) held++;
         else if (rd_now) held = 1;
         else held = 0;
         prev_rd = rd_now;
         rd_addr = mem_addr;
         mem_dq_in = (held >= ACC) ? ram_get(int'(mem_addr)) : ~ram_get(int'(mem_addr));
         if (rd_now) since = 0;
         else if (since < 1000) since++;
         if (mem_dq_oe) begin
            chk(!rd_now, "R7", "bus contention", int'(rd_now), 0);
            chk(since > TA, "R8", "float gap", since, TA + 1);
         end

         ov_now = !mem_cs1_n && mem_cs2 && !mem_we_n;
         if (ov_now) begin
            if (ov_prev && mem_dq_out == ov_d && mem_addr == ov_a) ov_cnt++;
            else ov_cnt = 1;
            ov_d = mem_dq_out;
            ov_a = mem_addr;
         end else if (ov_prev) begin
            chk(ov_cnt >= DW, "R5", "data setup cycles", ov_cnt, DW);
            chk(mem_dq_oe && mem_dq_out == ov_d, "R6", "data hold", int'(mem_dq_out), int'(ov_d));
            ram[int'(ov_a)] = ov_d;
         end
         ov_prev = ov_now;

         if (cur.v[6] && req_valid) push_op(req_write, req_addr, req_wdata);
      end
   end

   task automatic op(bit w, logic [12:0] a, logic [7:0] d);
      bit r;
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      r = 1'b0;
      while (!r) begin
         @(negedge clk);
         r = req_ready;
         @(posedge clk);
      end
      #1;
      req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = ~d;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R2 actual=busy expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      act = {req_ready, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid};
      chk(act === V_IDLE, "R1", "reset state", int'(act), int'(V_IDLE));
      @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      op(1'b1, 13'h0000, 8'h3C);          // first write, no gap (R8)
      op(1'b0, 13'h0000, 8'h00);          // read back (R10)
      op(1'b1, 13'h1FFF, 8'hC3);          // write after read, gap (R8)
      op(1'b1, 13'h0ABC, 8'h5A);          // write after write
      op(1'b0, 13'h1FFF, 8'h00);
      op(1'b0, 13'h0ABC, 8'h00);
      op(1'b0, 13'h1234, 8'h00);          // never written
      repeat (12) @(posedge clk);
      #1;
      for (int i = 0; i < 8; i++) op(1'b1, 13'(i * 1031), 8'(i * 37 + 5));
      for (int i = 7; i >= 0; i--) begin
         op(1'b0, 13'(i * 1031), 8'h00);
         if (i % 3 == 0) op(1'b1, 13'(i * 1031), 8'(i * 11 + 1));
      end
      for (int i = 0; i < 8; i++) op(1'b0, 13'(i * 1031), 8'h00);
      repeat (20) @(posedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule